// File: doc/BRIEF.md
# PDM In-Band Command Decoder

This block watches a one-bit oversampled PDM audio stream and pulls control settings out of it. The settings are carried in-band as silence patterns: long runs of one repeated byte value. A left/right select input picks whether this device's channel is the sample taken at the rising or at the falling edge of the PDM bit clock. The chosen samples are packed MSB-first into bytes. A run tracker counts how many identical bytes have arrived in a row. The control logic turns recognised runs into a power mode, a mute flag, a clip-control enable and a 2-bit gain code.

Everything runs on a fast reference clock. The PDM clock and data are resynchronised and their edges detected in the reference domain. A watchdog counts reference cycles between PDM clock edges. The first edge takes the block out of power-down, and a long gap sends it back. The outputs drive the amplifier datapath. The select pin is treated as quasi-static.

Top module: `pdm_cmd_decoder`

## Requirements
- R1: While reset is held and right after it, mode_oper is 0 (power-down), mute is 0, clip_en is 0 and gain is 2'b01 (0 dB).
- R2: With lr_sel 0, samples are taken at rising pdm_clk edges; with lr_sel 1, at falling edges. Eight consecutive samples form a byte with the first sample as bit 7. Byte alignment starts at the first sample after reset or after a clock loss.
- R3: The first pdm_clk edge after power-down sets mode_oper to 1, unless a power-down run is in force.
- R4: If no pdm_clk edge arrives for LOSS_CYCLES (256) reference cycles, mode_oper and mute go to 0 and byte alignment restarts. clip_en and gain keep their values. A shorter gap changes nothing.
- R5: mute goes to 1 once the 32nd consecutive 0x66 byte has been received, and not earlier. It stays 1 while 0x66 keeps repeating.
- R6: mute returns to 0 on the first byte that is not 0x66. An interrupted 0x66 run starts counting again from one.
- R7: After 128 consecutive 0xAC bytes, mode_oper goes to 0 and stays 0 however long 0xAC repeats. It returns to 1 on the first byte other than 0xAC.
- R8: After 128 consecutive 0xD2 bytes, clip_en goes to 1. No byte pattern clears it.
- R9: After 128 consecutive bytes of one gain value, gain takes a new code: 0x96 gives 2'b00 (-3 dB), 0x5A gives 2'b01 (0 dB), 0xA5 gives 2'b10 (+3 dB). A run of 127 leaves gain unchanged, and gain is never 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, much faster than pdm_clk |
| rst_n | input | 1 | Active-low reset |
| pdm_clk | input | 1 | PDM bit clock |
| pdm_data | input | 1 | PDM data, two channels interleaved on the clock edges |
| lr_sel | input | 1 | Channel select: 0 rising-edge sample, 1 falling-edge sample |
| mode_oper | output | 1 | 1 operating, 0 power-down |
| mute | output | 1 | Hard mute |
| clip_en | output | 1 | Clip control enable |
| gain | output | 2 | Gain code: 00 -3 dB, 01 0 dB, 10 +3 dB |

## Verification
On every cycle, the bound checker confirms these rules: mute only rises right after a 0x66 run report and only falls after a different byte or a clock loss; the operating mode only drops on a clock loss or an 0xAC report; a clock loss always forces power-down; clip control never clears; gain moves only on a run report and never takes the unused code. The exact run thresholds cannot be shown by the checker, so the bench's scenarios cover them: nothing at 31 or 127 bytes, action at 32 or 128. The bench scenarios also cover MSB-first byte order, the effect of the channel select, saturation over long power-down runs, and the settings kept across a clock loss.

// File: rtl/pdm_cmd_pkg.sv
package pdm_cmd_pkg;
   typedef enum logic [1:0] {
      GAIN_NEG3 = 2'b00,
      GAIN_ZERO = 2'b01,
      GAIN_POS3 = 2'b10
   } gain_e;
endpackage

// File: rtl/pdm_edge_sampler.sv
module pdm_edge_sampler #(
   parameter int SYNC_STAGES = 2,
   parameter int LOSS_CYCLES = 256
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pdm_clk,
   input  logic pdm_data,
   input  logic lr_sel,
   output logic samp_valid,
   output logic samp_bit,
   output logic alive,
   output logic lost
);
   localparam int LW = $clog2(LOSS_CYCLES + 1);

   logic [SYNC_STAGES-1:0] clk_sync;
   logic [SYNC_STAGES-1:0] dat_sync;
   logic                   clk_prev;
   logic                   s_clk, s_dat, rise, fall, any_edge;
   logic [LW-1:0]          gap_cnt;

   generate
      if (SYNC_STAGES == 1) begin : g_one
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clk_sync <= '0;
               dat_sync <= '0;
            end else begin
               clk_sync <= pdm_clk;
               dat_sync <= pdm_data;
            end
         end
      end else begin : g_chain
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               clk_sync <= '0;
               dat_sync <= '0;
            end else begin
               clk_sync <= {clk_sync[SYNC_STAGES-2:0], pdm_clk};
               dat_sync <= {dat_sync[SYNC_STAGES-2:0], pdm_data};
            end
         end
      end
   endgenerate

   assign s_clk    = clk_sync[SYNC_STAGES-1];
   assign s_dat    = dat_sync[SYNC_STAGES-1];
   assign rise     = s_clk & ~clk_prev;
   assign fall     = ~s_clk & clk_prev;
   assign any_edge = rise | fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clk_prev   <= 1'b0;
         samp_valid <= 1'b0;
         samp_bit   <= 1'b0;
         alive      <= 1'b0;
         lost       <= 1'b0;
         gap_cnt    <= '0;
      end else begin
         clk_prev   <= s_clk;
         samp_valid <= lr_sel ? fall : rise;
         samp_bit   <= s_dat;
         lost       <= 1'b0;
         if (any_edge) begin
            alive   <= 1'b1;
            gap_cnt <= '0;
         end else if (alive) begin
            if (gap_cnt == LW'(LOSS_CYCLES - 1)) begin
               alive   <= 1'b0;
               lost    <= 1'b1;
               gap_cnt <= '0;
            end else begin
               gap_cnt <= gap_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pdm_byte_packer.sv
module pdm_byte_packer #(
   parameter int BYTE_W    = 8,
   parameter bit MSB_FIRST = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              samp_valid,
   input  logic              samp_bit,
   output logic              byte_valid,
   output logic [BYTE_W-1:0] byte_val
);
   localparam int CW = $clog2(BYTE_W);

   logic [BYTE_W-1:0] shreg, shnext;
   logic [CW-1:0]     bit_cnt;

   generate
      if (MSB_FIRST) begin : g_msb
         assign shnext = {shreg[BYTE_W-2:0], samp_bit};
      end else begin : g_lsb
         assign shnext = {samp_bit, shreg[BYTE_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg      <= '0;
         bit_cnt    <= '0;
         byte_valid <= 1'b0;
         byte_val   <= '0;
      end else begin
         byte_valid <= 1'b0;
         if (restart) begin
            bit_cnt <= '0;
         end else if (samp_valid) begin
            shreg <= shnext;
            if (bit_cnt == CW'(BYTE_W - 1)) begin
               bit_cnt    <= '0;
               byte_valid <= 1'b1;
               byte_val   <= shnext;
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/pdm_run_tracker.sv
module pdm_run_tracker #(
   parameter int BYTE_W  = 8,
   parameter int RUN_SAT = 128,
   localparam int RUN_W  = $clog2(RUN_SAT + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              restart,
   input  logic              byte_valid,
   input  logic [BYTE_W-1:0] byte_val,
   output logic              run_valid,
   output logic [BYTE_W-1:0] run_byte,
   output logic [RUN_W-1:0]  run_len
);
   logic have_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_valid <= 1'b0;
         run_byte  <= '0;
         run_len   <= '0;
         have_prev <= 1'b0;
      end else begin
         run_valid <= 1'b0;
         if (restart) begin
            run_len   <= '0;
            have_prev <= 1'b0;
         end else if (byte_valid) begin
            run_valid <= 1'b1;
            run_byte  <= byte_val;
            have_prev <= 1'b1;
            if (have_prev && byte_val == run_byte) begin
               if (run_len != RUN_W'(RUN_SAT))
                  run_len <= run_len + 1'b1;
            end else begin
               run_len <= RUN_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/pdm_cmd_decoder.sv
module pdm_cmd_decoder #(
   parameter int         BYTE_W      = 8,
   parameter int         SYNC_STAGES = 2,
   parameter int         LOSS_CYCLES = 256,
   parameter int         MUTE_RUN    = 32,
   parameter int         CFG_RUN     = 128,
   parameter logic [7:0] MUTE_BYTE   = 8'h66,
   parameter logic [7:0] PDOWN_BYTE  = 8'hAC,
   parameter logic [7:0] CLIP_BYTE   = 8'hD2,
   parameter logic [7:0] GLOW_BYTE   = 8'h96,
   parameter logic [7:0] GMID_BYTE   = 8'h5A,
   parameter logic [7:0] GHIGH_BYTE  = 8'hA5
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pdm_clk,
   input  logic       pdm_data,
   input  logic       lr_sel,
   output logic       mode_oper,
   output logic       mute,
   output logic       clip_en,
   output logic [1:0] gain
);
   import pdm_cmd_pkg::*;

   localparam int RUN_W = $clog2(CFG_RUN + 1);

   initial begin
      assert (BYTE_W == 8) else $error("pattern bytes are 8 bits wide");
      assert (SYNC_STAGES >= 1) else $error("need at least one sync stage");
      assert (LOSS_CYCLES >= 4) else $error("loss window too short");
      assert (MUTE_RUN >= 1 && MUTE_RUN <= CFG_RUN) else $error("mute run must fit the run counter");
   end

   logic              samp_valid, samp_bit, alive, lost;
   logic              byte_valid;
   logic [BYTE_W-1:0] byte_val;
   logic              run_valid;
   logic [BYTE_W-1:0] run_byte;
   logic [RUN_W-1:0]  run_len;
   logic              pd_hold, pd_hold_d, cfg_hit;
   gain_e             gain_q;

   pdm_edge_sampler #(.SYNC_STAGES(SYNC_STAGES), .LOSS_CYCLES(LOSS_CYCLES)) u_samp (
      .clk(clk), .rst_n(rst_n), .pdm_clk(pdm_clk), .pdm_data(pdm_data),
      .lr_sel(lr_sel), .samp_valid(samp_valid), .samp_bit(samp_bit),
      .alive(alive), .lost(lost));

   pdm_byte_packer #(.BYTE_W(BYTE_W), .MSB_FIRST(1'b1)) u_pack (
      .clk(clk), .rst_n(rst_n), .restart(lost), .samp_valid(samp_valid),
      .samp_bit(samp_bit), .byte_valid(byte_valid), .byte_val(byte_val));

   pdm_run_tracker #(.BYTE_W(BYTE_W), .RUN_SAT(CFG_RUN)) u_run (
      .clk(clk), .rst_n(rst_n), .restart(lost), .byte_valid(byte_valid),
      .byte_val(byte_val), .run_valid(run_valid), .run_byte(run_byte),
      .run_len(run_len));

   assign cfg_hit = run_valid && (run_len >= RUN_W'(CFG_RUN));

   always_comb begin
      pd_hold_d = pd_hold;
      if (run_valid) begin
         if (run_byte == PDOWN_BYTE)
            pd_hold_d = pd_hold | cfg_hit;
         else
            pd_hold_d = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_oper <= 1'b0;
         mute      <= 1'b0;
         pd_hold   <= 1'b0;
         clip_en   <= 1'b0;
         gain_q    <= GAIN_ZERO;
      end else if (lost) begin
         mode_oper <= 1'b0;
         mute      <= 1'b0;
         pd_hold   <= 1'b0;
      end else begin
         pd_hold   <= pd_hold_d;
         mode_oper <= alive & ~pd_hold_d;
         if (run_valid)
            mute <= (run_byte == MUTE_BYTE) && (run_len >= RUN_W'(MUTE_RUN));
         if (cfg_hit && run_byte == CLIP_BYTE)
            clip_en <= 1'b1;
         if (cfg_hit) begin
            if (run_byte == GLOW_BYTE)       gain_q <= GAIN_NEG3;
            else if (run_byte == GMID_BYTE)  gain_q <= GAIN_ZERO;
            else if (run_byte == GHIGH_BYTE) gain_q <= GAIN_POS3;
         end
      end
   end

   assign gain = gain_q;
endmodule

// File: rtl/pdm_cmd_decoder_chk.sv
module pdm_cmd_decoder_chk #(
   parameter logic [7:0] MUTE_BYTE  = 8'h66,
   parameter logic [7:0] PDOWN_BYTE = 8'hAC
) (
   input logic       clk,
   input logic       rst_n,
   input logic       mode_oper,
   input logic       mute,
   input logic       clip_en,
   input logic [1:0] gain,
   input logic       run_valid,
   input logic [7:0] run_byte,
   input logic       lost,
   input logic       alive
);
   a_r3_mode_needs_clock: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mode_oper) |-> $past(alive));
   a_r4_loss_forces_pdown: assert property (@(posedge clk) disable iff (!rst_n)
      lost |=> !mode_oper && !mute);
   a_r5_mute_from_pattern: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mute) |-> $past(run_valid) && $past(run_byte) == MUTE_BYTE);
   a_r6_unmute_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mute) |-> $past(lost) || ($past(run_valid) && $past(run_byte) != MUTE_BYTE));
   a_r7_pdown_cause: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mode_oper) |-> $past(lost) || ($past(run_valid) && $past(run_byte) == PDOWN_BYTE));
   a_r8_clip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      clip_en |=> clip_en);
   a_r9_gain_legal: assert property (@(posedge clk) disable iff (!rst_n)
      gain != 2'b11);
   a_r9_gain_on_run: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(gain) |-> $past(run_valid));
endmodule

bind pdm_cmd_decoder pdm_cmd_decoder_chk #(
   .MUTE_BYTE(MUTE_BYTE), .PDOWN_BYTE(PDOWN_BYTE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_oper(mode_oper), .mute(mute),
   .clip_en(clip_en), .gain(gain), .run_valid(run_valid),
   .run_byte(run_byte), .lost(lost), .alive(alive));

// File: tb/tb_pdm_cmd_decoder.sv
module tb_pdm_cmd_decoder;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pdm_clk = 1'b0;
   logic       pdm_data = 1'b0;
   logic       lr_sel = 1'b0;
   logic       mode_oper, mute, clip_en;
   logic [1:0] gain;
   int         checks = 0;
   int         errors = 0;
   bit         done = 1'b0;

   always #5 clk = ~clk;

   pdm_cmd_decoder dut (
      .clk(clk), .rst_n(rst_n), .pdm_clk(pdm_clk), .pdm_data(pdm_data),
      .lr_sel(lr_sel), .mode_oper(mode_oper), .mute(mute),
      .clip_en(clip_en), .gain(gain));

   // exp = {mode_oper, mute, clip_en, gain}
   typedef struct packed {
      logic [3:0] req;
      logic [7:0] val;
      logic [8:0] cnt;
      logic [4:0] exp;
   } vec_t;

   localparam int NV = 19;
   localparam vec_t VEC [NV] = '{
      '{4'd3, 8'h00, 9'd4,   5'b10001},  // R3 clock wakes block
      '{4'd5, 8'h66, 9'd31,  5'b10001},  // R5 31 not enough
      '{4'd5, 8'h66, 9'd1,   5'b11001},  // R5 32nd byte mutes
      '{4'd5, 8'h66, 9'd50,  5'b11001},  // R5 stays muted
      '{4'd6, 8'h00, 9'd1,   5'b10001},  // R6 first other byte unmutes
      '{4'd7, 8'hAC, 9'd127, 5'b10001},  // R7 127 not enough
      '{4'd7, 8'hAC, 9'd1,   5'b00001},  // R7 128th powers down
      '{4'd7, 8'hAC, 9'd200, 5'b00001},  // R7 saturation, stays down
      '{4'd7, 8'h00, 9'd1,   5'b10001},  // R7 break wakes
      '{4'd8, 8'hD2, 9'd127, 5'b10001},  // R8 127 not enough
      '{4'd8, 8'hD2, 9'd1,   5'b10101},  // R8 clip on
      '{4'd9, 8'hA5, 9'd128, 5'b10110},  // R9 +3 dB
      '{4'd9, 8'h96, 9'd127, 5'b10110},  // R9 127 not enough
      '{4'd9, 8'h96, 9'd1,   5'b10100},  // R9 -3 dB
      '{4'd9, 8'h5A, 9'd128, 5'b10101},  // R9 0 dB
      '{4'd6, 8'h66, 9'd20,  5'b10101},  // R6 partial run
      '{4'd6, 8'h11, 9'd1,   5'b10101},  // R6 break
      '{4'd6, 8'h66, 9'd31,  5'b10101},  // R6 count restarted
      '{4'd5, 8'h66, 9'd1,   5'b11101}   // R5 mutes after fresh 32
   };

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input int req, input logic [4:0] exp);
      logic [4:0] act;
      act = {mode_oper, mute, clip_en, gain};
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d: {mode,mute,clip,gain} actual %b expected %b", req, act, exp);
      end
   endtask

   // R2: own channel sample on selected edge, other channel gets the inverse
   task automatic send_byte(input logic [7:0] v, input int n);
      for (int k = 0; k < n; k++) begin
         for (int i = 7; i >= 0; i--) begin
            pdm_data = lr_sel ? ~v[i] : v[i];
            wait_cyc(2);
            pdm_clk = 1'b1;
            wait_cyc(2);
            pdm_data = lr_sel ? v[i] : ~v[i];
            wait_cyc(2);
            pdm_clk = 1'b0;
            wait_cyc(2);
         end
      end
   endtask

   initial begin
      wait_cyc(3);
      check(1, 5'b00001);                // R1 during reset
      rst_n = 1'b1;
      wait_cyc(5);
      check(1, 5'b00001);                // R1 after reset, no clock
      for (int r = 0; r < NV; r++) begin
         send_byte(VEC[r].val, int'(VEC[r].cnt));
         wait_cyc(12);
         check(int'(VEC[r].req), VEC[r].exp);
      end
      // R4: short gap harmless, long gap powers down, settings kept
      wait_cyc(200);
      check(4, 5'b11101);
      wait_cyc(100);
      check(4, 5'b00101);
      // R2: falling-edge channel, MSB-first, fresh alignment
      lr_sel = 1'b1;
      send_byte(8'h00, 2);
      wait_cyc(12);
      check(2, 5'b10101);
      send_byte(8'h66, 32);
      wait_cyc(12);
      check(2, 5'b11101);
      send_byte(8'hAC, 128);
      wait_cyc(12);
      check(2, 5'b00101);
      send_byte(8'hD2, 1);
      wait_cyc(12);
      check(7, 5'b10101);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule